// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block keeps the per-channel transfer state of a multi-channel byte mover that works on a byte-addressed data memory. Each channel holds a start address, a length in bytes, a running offset, a configuration byte and an enable bit. When the transfer engine moves a byte for a channel, the offset advances. The block presents the memory address of the channel being served and raises half-way and end-of-transfer flags.

Software programs a channel indirectly. It first writes a select register, then writes the per-channel registers through an 8-bit register port. The enable bits form one shared register that is written directly, whatever the select holds. An external arbiter names the channel it serves on `xfer_ch` and pulses `xfer_byte` once for each byte moved.

For 16-bit words, the channel's byte-order bit decides whether the two bytes of the word pass through unchanged or swapped.

Register addresses on `wr_addr`:

| Address | Register |
|---|---|
| 0 | Channel select |
| 1 | Configuration |
| 2 | Base low byte |
| 3 | Base high byte |
| 4 | Size low byte |
| 5 | Size high byte |
| 6 | Offset low byte |
| 7 | Offset high byte |
| 8 | Shared enable |

Configuration bits:

| Bit | Meaning |
|---|---|
| 0 | End interrupt enable |
| 1 | Half-way interrupt enable |
| 2 | Big-endian (swap bytes) |
| 5:4 | Transfer function code |

Top module: `dma_addr_engine`

## Requirements
- R1: After reset, every channel's base, size, offset and configuration are zero, the select is 0, and `ch_en`, `irq_full` and `irq_mid` are all zero.
- R2: A write to address 0 loads the select from `wr_data[CH_W-1:0]`. Writes to addresses 1 to 7 change only the channel named by the select held before that write.
- R3: `mem_addr` equals the base plus the offset of the channel on `xfer_ch`, modulo 2^ADDR_W.
- R4: A byte is accepted when `xfer_byte` is high, the channel on `xfer_ch` is enabled, and its offset differs from its size. On acceptance, the offset grows by one in the next cycle. Without acceptance, the offset is unchanged, so a disabled channel or a finished channel ignores `xfer_byte`.
- R5: A write to address 8 loads `ch_en[i]` from `wr_data[i]` for every channel, regardless of the select.
- R6: An accepted byte that makes the offset equal the size sets that channel's end flag and clears its enable bit.
- R7: With a size of at least 2, an accepted byte that makes the offset equal floor(size/2) sets that channel's half-way flag.
- R8: `irq_full[i]` is the end flag of channel i gated by configuration bit 0. `irq_mid[i]` is the half-way flag gated by configuration bit 1.
- R9: A write to address 6 or 7 loads the low or high byte of the selected channel's offset and clears both of its flags. Writing zero to both bytes restarts the count.
- R10: When configuration bit 2 of the channel on `xfer_ch` is set, `data_out` is `data_in` with its two bytes swapped. Otherwise `data_out` equals `data_in`.
- R11: `xfer_func` shows configuration bits 5:4 of the channel on `xfer_ch`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| xfer_byte | input | 1 | One byte moved for `xfer_ch` |
| xfer_ch | input | CH_W | Channel being served |
| data_in | input | 16 | Word on the data path |
| mem_addr | output | ADDR_W | Memory address of the served channel |
| data_out | output | 16 | Word after byte-order handling |
| xfer_func | output | 2 | Function code of the served channel |
| ch_en | output | NUM_CH | Channel enable bits |
| irq_full | output | NUM_CH | End-of-transfer interrupts |
| irq_mid | output | NUM_CH | Half-way interrupts |

## Verification
The assertions assume that software never writes a channel's registers in the same cycle that the channel accepts a byte. They also assume that the enable register is not written in the cycle a channel completes. Their implications therefore hold only in cycles without a register write. The stimulus keeps register writes and byte strobes in separate cycles, and starts each transfer only after the channel is fully programmed, so every step the checker sees is a clean count step.

// File: rtl/dma_ace_pkg.sv
package dma_ace_pkg;

   localparam int REG_W  = 8;
   localparam int WORD_W = 16;

   typedef enum logic [3:0] {
      RA_SEL    = 4'd0,
      RA_CFG    = 4'd1,
      RA_BASE_L = 4'd2,
      RA_BASE_H = 4'd3,
      RA_SIZE_L = 4'd4,
      RA_SIZE_H = 4'd5,
      RA_OFS_L  = 4'd6,
      RA_OFS_H  = 4'd7,
      RA_ENABLE = 4'd8
   } reg_addr_e;

   typedef struct packed {
      logic [1:0] spare_hi;
      logic [1:0] func;
      logic       spare_lo;
      logic       big_end;
      logic       ie_mid;
      logic       ie_full;
   } ch_cfg_t;

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_ace_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int SIZE_W = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  sel_hit,
   input  logic                  wr_en,
   input  logic [3:0]            wr_addr,
   input  logic [REG_W-1:0]      wr_data,
   input  logic                  en_wr,
   input  logic                  en_val,
   input  logic                  step,
   output logic [ADDR_W-1:0]     base,
   output logic [SIZE_W-1:0]     size,
   output logic [SIZE_W-1:0]     ofs,
   output ch_cfg_t               cfg,
   output logic                  en,
   output logic                  flag_full,
   output logic                  flag_mid,
   output logic                  acc
);

   logic [SIZE_W-1:0] ofs_nx;
   logic [SIZE_W-1:0] half;
   logic              hit;

   assign acc    = step && en && (ofs != size);
   assign ofs_nx = ofs + 1'b1;
   assign half   = size >> 1;
   assign hit    = wr_en && sel_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base      <= '0;
         size      <= '0;
         ofs       <= '0;
         cfg       <= '0;
         en        <= 1'b0;
         flag_full <= 1'b0;
         flag_mid  <= 1'b0;
      end else begin
         if (acc) begin
            ofs <= ofs_nx;
            if (ofs_nx == size) begin
               flag_full <= 1'b1;
               en        <= 1'b0;
            end
            if ((size >= SIZE_W'(2)) && (ofs_nx == half))
               flag_mid <= 1'b1;
         end
         if (en_wr)
            en <= en_val;
         if (hit) begin
            case (reg_addr_e'(wr_addr))
               RA_CFG:    cfg <= ch_cfg_t'(wr_data);
               RA_BASE_L: base[7:0] <= wr_data;
               RA_BASE_H: base[ADDR_W-1:8] <= wr_data[ADDR_W-9:0];
               RA_SIZE_L: size[7:0] <= wr_data;
               RA_SIZE_H: size[SIZE_W-1:8] <= wr_data[SIZE_W-9:0];
               RA_OFS_L: begin
                  ofs[7:0]  <= wr_data;
                  flag_full <= 1'b0;
                  flag_mid  <= 1'b0;
               end
               RA_OFS_H: begin
                  ofs[SIZE_W-1:8] <= wr_data[SIZE_W-9:0];
                  flag_full       <= 1'b0;
                  flag_mid        <= 1'b0;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/dma_out_mux.sv
module dma_out_mux
   import dma_ace_pkg::*;
#(
   parameter int NUM_CH   = 4,
   parameter int ADDR_W   = 16,
   parameter int SIZE_W   = 16,
   parameter bit SWAP_OK  = 1'b1,
   localparam int CH_W    = $clog2(NUM_CH)
) (
   input  logic [NUM_CH-1:0][ADDR_W-1:0] base_a,
   input  logic [NUM_CH-1:0][SIZE_W-1:0] ofs_a,
   input  ch_cfg_t [NUM_CH-1:0]          cfg_a,
   input  logic [CH_W-1:0]               xfer_ch,
   input  logic [WORD_W-1:0]             data_in,
   output logic [ADDR_W-1:0]             mem_addr,
   output logic [WORD_W-1:0]             data_out,
   output logic [1:0]                    xfer_func
);

   ch_cfg_t cur_cfg;

   assign cur_cfg   = cfg_a[xfer_ch];
   assign mem_addr  = base_a[xfer_ch] + ADDR_W'(ofs_a[xfer_ch]);
   assign xfer_func = cur_cfg.func;

   generate
      if (SWAP_OK) begin : g_swap
         assign data_out = cur_cfg.big_end ? {data_in[7:0], data_in[15:8]} : data_in;
      end else begin : g_pass
         assign data_out = data_in;
      end
   endgenerate

endmodule

// File: rtl/dma_addr_engine.sv
module dma_addr_engine
   import dma_ace_pkg::*;
#(
   parameter int NUM_CH  = 4,
   parameter int ADDR_W  = 16,
   parameter int SIZE_W  = 16,
   parameter bit SWAP_OK = 1'b1,
   localparam int CH_W   = $clog2(NUM_CH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [3:0]        wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic              xfer_byte,
   input  logic [CH_W-1:0]   xfer_ch,
   input  logic [WORD_W-1:0] data_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [WORD_W-1:0] data_out,
   output logic [1:0]        xfer_func,
   output logic [NUM_CH-1:0] ch_en,
   output logic [NUM_CH-1:0] irq_full,
   output logic [NUM_CH-1:0] irq_mid
);

   if (NUM_CH < 2 || NUM_CH > REG_W || (NUM_CH & (NUM_CH - 1)) != 0) begin : g_bad_ch
      $error("NUM_CH must be a power of two from 2 to 8");
   end
   if (ADDR_W < 9 || ADDR_W > 16) begin : g_bad_addr
      $error("ADDR_W must lie in 9..16");
   end
   if (SIZE_W < 9 || SIZE_W > 16) begin : g_bad_size
      $error("SIZE_W must lie in 9..16");
   end

   logic [CH_W-1:0]               sel_q;
   logic                          en_wr;
   logic [NUM_CH-1:0][ADDR_W-1:0] base_q;
   logic [NUM_CH-1:0][SIZE_W-1:0] size_q;
   logic [NUM_CH-1:0][SIZE_W-1:0] ofs_q;
   ch_cfg_t [NUM_CH-1:0]          cfg_q;
   logic [NUM_CH-1:0]             flag_full_v;
   logic [NUM_CH-1:0]             flag_mid_v;
   logic [NUM_CH-1:0]             acc_v;

   assign en_wr = wr_en && (wr_addr == RA_ENABLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sel_q <= '0;
      else if (wr_en && (wr_addr == RA_SEL))
         sel_q <= wr_data[CH_W-1:0];
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      dma_chan_regs #(
         .ADDR_W (ADDR_W),
         .SIZE_W (SIZE_W)
      ) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .sel_hit   (sel_q == CH_W'(c)),
         .wr_en     (wr_en),
         .wr_addr   (wr_addr),
         .wr_data   (wr_data),
         .en_wr     (en_wr),
         .en_val    (wr_data[c]),
         .step      (xfer_byte && (xfer_ch == CH_W'(c))),
         .base      (base_q[c]),
         .size      (size_q[c]),
         .ofs       (ofs_q[c]),
         .cfg       (cfg_q[c]),
         .en        (ch_en[c]),
         .flag_full (flag_full_v[c]),
         .flag_mid  (flag_mid_v[c]),
         .acc       (acc_v[c])
      );
      assign irq_full[c] = flag_full_v[c] & cfg_q[c].ie_full;
      assign irq_mid[c]  = flag_mid_v[c] & cfg_q[c].ie_mid;
   end

   dma_out_mux #(
      .NUM_CH  (NUM_CH),
      .ADDR_W  (ADDR_W),
      .SIZE_W  (SIZE_W),
      .SWAP_OK (SWAP_OK)
   ) u_mux (
      .base_a    (base_q),
      .ofs_a     (ofs_q),
      .cfg_a     (cfg_q),
      .xfer_ch   (xfer_ch),
      .data_in   (data_in),
      .mem_addr  (mem_addr),
      .data_out  (data_out),
      .xfer_func (xfer_func)
   );

endmodule

// File: rtl/dma_addr_engine_chk.sv
module dma_addr_engine_chk #(
   parameter int NUM_CH = 4,
   parameter int SIZE_W = 16
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          wr_en,
   input logic [NUM_CH-1:0][SIZE_W-1:0] ofs,
   input logic [NUM_CH-1:0][SIZE_W-1:0] size,
   input logic [NUM_CH-1:0]             en,
   input logic [NUM_CH-1:0]             acc,
   input logic [NUM_CH-1:0]             flag_full
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_a
      // R4: an accepted byte advances the offset by exactly one
      a_r4_step_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
         (acc[c] && !wr_en) |=> (ofs[c] == $past(ofs[c]) + 1'b1));

      // R4: without acceptance or a write, the offset holds
      a_r4_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
         (!acc[c] && !wr_en) |=> $stable(ofs[c]));

      // R6: the byte that reaches the size clears the enable
      a_r6_done_disables: assert property (@(posedge clk) disable iff (!rst_n)
         (acc[c] && !wr_en && (ofs[c] + 1'b1 == size[c])) |=> !en[c]);

      // R6: the end flag only rises after an accepted byte
      a_r6_full_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(flag_full[c]) |-> $past(acc[c]));
   end

endmodule

bind dma_addr_engine dma_addr_engine_chk #(
   .NUM_CH (NUM_CH),
   .SIZE_W (SIZE_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .ofs       (ofs_q),
   .size      (size_q),
   .en        (ch_en),
   .acc       (acc_v),
   .flag_full (flag_full_v)
);

// File: tb/sim_dma_addr_engine.sv
module sim_dma_addr_engine;

   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        xfer_byte = 1'b0;
   logic [1:0]  xfer_ch = '0;
   logic [15:0] data_in = '0;
   logic [15:0] mem_addr;
   logic [15:0] data_out;
   logic [1:0]  xfer_func;
   logic [3:0]  ch_en, irq_full, irq_mid;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;

   int m_base[NCH], m_size[NCH], m_ofs[NCH], m_cfg[NCH];
   bit m_en[NCH], m_ff[NCH], m_fm[NCH];
   int m_sel;

   always #4 clk = ~clk;

   dma_addr_engine u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .xfer_byte(xfer_byte), .xfer_ch(xfer_ch),
      .data_in(data_in), .mem_addr(mem_addr), .data_out(data_out),
      .xfer_func(xfer_func), .ch_en(ch_en), .irq_full(irq_full),
      .irq_mid(irq_mid)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // Behavioural reference: register writes win over the byte step.
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NCH; i++) begin
            m_base[i] = 0; m_size[i] = 0; m_ofs[i] = 0; m_cfg[i] = 0;
            m_en[i] = 0; m_ff[i] = 0; m_fm[i] = 0;
         end
         m_sel = 0;
      end else begin
         int c, nxt;
         c = int'(xfer_ch);
         if (xfer_byte && m_en[c] && m_ofs[c] != m_size[c]) begin
            nxt = (m_ofs[c] + 1) % 65536;
            m_ofs[c] = nxt;
            if (nxt == m_size[c]) begin m_ff[c] = 1; m_en[c] = 0; end
            if (m_size[c] >= 2 && nxt == m_size[c] / 2) m_fm[c] = 1;
         end
         if (wr_en) begin
            case (int'(wr_addr))
               0: m_sel = int'(wr_data) % NCH;
               1: m_cfg[m_sel] = int'(wr_data);
               2: m_base[m_sel] = (m_base[m_sel] & 'hFF00) | int'(wr_data);
               3: m_base[m_sel] = (m_base[m_sel] & 'h00FF) | (int'(wr_data) << 8);
               4: m_size[m_sel] = (m_size[m_sel] & 'hFF00) | int'(wr_data);
               5: m_size[m_sel] = (m_size[m_sel] & 'h00FF) | (int'(wr_data) << 8);
               6: begin m_ofs[m_sel] = (m_ofs[m_sel] & 'hFF00) | int'(wr_data);
                        m_ff[m_sel] = 0; m_fm[m_sel] = 0; end
               7: begin m_ofs[m_sel] = (m_ofs[m_sel] & 'h00FF) | (int'(wr_data) << 8);
                        m_ff[m_sel] = 0; m_fm[m_sel] = 0; end
               8: for (int i = 0; i < NCH; i++) m_en[i] = wr_data[i];
               default: ;
            endcase
         end
      end
   end

   // Compare against the reference on every clock, after outputs settle.
   always @(posedge clk) begin
      #1;
      if (!finished) begin
         int c;
         logic [3:0] e_en, e_if, e_im;
         c = int'(xfer_ch);
         for (int i = 0; i < NCH; i++) begin
            e_en[i] = m_en[i];
            e_if[i] = m_ff[i] && m_cfg[i][0];
            e_im[i] = m_fm[i] && m_cfg[i][1];
         end
         chk("R3 mem_addr", 32'(mem_addr), 32'((m_base[c] + m_ofs[c]) % 65536));
         chk("R10 data_out", 32'(data_out),
             m_cfg[c][2] ? 32'({data_in[7:0], data_in[15:8]}) : 32'(data_in));
         chk("R11 xfer_func", 32'(xfer_func), 32'((m_cfg[c] >> 4) & 3));
         chk("R5/R6 ch_en", 32'(ch_en), 32'(e_en));
         chk("R8 irq_full", 32'(irq_full), 32'(e_if));
         chk("R8 irq_mid", 32'(irq_mid), 32'(e_im));
      end
   end

   task automatic wr(input int a, input int d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic mv(input int ch, input logic [15:0] d);
      @(negedge clk);
      xfer_byte = 1'b1; xfer_ch = 2'(ch); data_in = d;
      @(negedge clk);
      xfer_byte = 1'b0;
   endtask

   task automatic setup(input int ch, input int cfg, input int base, input int size);
      wr(0, ch); wr(1, cfg);
      wr(2, base & 'hFF); wr(3, base >> 8);
      wr(4, size & 'hFF); wr(5, size >> 8);
      wr(6, 0); wr(7, 0);
   endtask

   initial begin
      #(8 * 150000);
      if (!finished) begin
         finished = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk("R1 ch_en", 32'(ch_en), 0);
      chk("R1 irq_full", 32'(irq_full), 0);
      chk("R1 irq_mid", 32'(irq_mid), 0);
      chk("R1 mem_addr", 32'(mem_addr), 0);

      setup(1, 'h13, 'h1234, 6);
      setup(2, 'h04, 'hFFFE, 4);
      // R2: channel 0 untouched by writes aimed at channels 1 and 2
      xfer_ch = 2'd0; @(negedge clk);
      chk("R2 ch0 addr", 32'(mem_addr), 0);
      xfer_ch = 2'd1; @(negedge clk);
      chk("R2 ch1 addr", 32'(mem_addr), 'h1234);
      chk("R11 ch1 func", 32'(xfer_func), 1);

      wr(8, 'h06);
      chk("R5 enable", 32'(ch_en), 'h6);

      // R4: disabled channel ignores a byte
      mv(0, 16'h1111);
      chk("R4 disabled ch0", 32'(mem_addr), 0);

      for (int i = 0; i < 3; i++) mv(1, 16'(16'h0100 + i));
      chk("R7 mid ch1", 32'(irq_mid[1]), 1);
      chk("R7 full not yet", 32'(irq_full[1]), 0);
      chk("R10 ch1 pass", 32'(data_out), 'h0102);
      for (int i = 0; i < 3; i++) mv(1, 16'(16'h0200 + i));
      chk("R6 full ch1", 32'(irq_full[1]), 1);
      chk("R6 en cleared", 32'(ch_en[1]), 0);
      mv(1, 16'h0300);
      chk("R4 finished ignores", 32'(mem_addr), 'h123A);

      mv(2, 16'hA1B2);
      chk("R10 ch2 swap", 32'(data_out), 'hB2A1);
      mv(2, 16'hC3D4);
      chk("R3 wrap", 32'(mem_addr), 'h0000);
      mv(2, 16'h0001); mv(2, 16'h0002);
      chk("R8 gated full", 32'(irq_full[2]), 0);
      chk("R6 ch2 stopped", 32'(ch_en[2]), 0);

      // R9: offset rewrite restarts and clears flags
      wr(0, 1); wr(6, 0); wr(7, 0);
      xfer_ch = 2'd1; @(negedge clk);
      chk("R9 flags clear", 32'({irq_full[1], irq_mid[1]}), 0);
      chk("R9 addr restart", 32'(mem_addr), 'h1234);

      // R7: odd size 5 on channel 0 -> half-way at offset 2
      setup(0, 'h02, 'h0040, 5);
      wr(8, 'h01);
      mv(0, 16'h0); chk("R7 odd early", 32'(irq_mid[0]), 0);
      mv(0, 16'h0); chk("R7 odd mid", 32'(irq_mid[0]), 1);
      mv(0, 16'h0); mv(0, 16'h0); mv(0, 16'h0);
      chk("R6 ch0 done", 32'(ch_en[0]), 0);

      // R4: size zero channel accepts nothing
      wr(0, 3); wr(8, 'h08);
      mv(3, 16'h0);
      chk("R4 size zero addr", 32'(mem_addr), 0);
      chk("R4 size zero en", 32'(ch_en[3]), 1);

      repeat (4) @(negedge clk);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule